// File: doc/BRIEF.md
# Alarm Comparator Bank

This block holds a small set of alarm comparators that sit beside two free-running 52-bit tick counters. Each comparator watches one of the two counts, chosen by a per-comparator select bit, and raises an alarm in one of two ways. In one-shot mode it fires a single time once the watched count has reached an absolute 52-bit deadline. In repeating mode it fires every N ticks, where N comes from a 26-bit interval.

Software-side settings arrive through a narrow write port. A deadline is written in two halves: a 32-bit low word and a 20-bit upper part. The interval is written as a single word. Every write lands in a per-comparator staging copy. Nothing reaches the live compare logic until that comparator's commit strobe is pulsed.

Each comparator drives a one-clock event pulse, meant for a routing fabric. It also sets a sticky pending bit. The pending bit is masked by an enable and can be cleared with a write-one strobe.

Top module: `alarm_bank`

## Requirements
- R1: Writes to a comparator's staged deadline or staged interval do not change its live compare values until its `load` bit is pulsed.
- R2: In one-shot mode (`period_mode` bit 0), a comparator that has been committed and is enabled pulses `evt` for exactly one clock. It also sets its `int_raw` bit. Both are visible after the first rising edge at which the watched count is greater than or equal to the live deadline.
- R3: After a one-shot alarm, that comparator does not fire again until its next `load` pulse.
- R4: A `unit_sel` bit of 0 makes the comparator watch `cnt_u0`. A value of 1 makes it watch `cnt_u1`.
- R5: While a comparator's `work_en` bit is 0 it never fires. A pending one-shot alarm is kept and fires after the bit returns to 1.
- R6: A 0-to-1 change of a comparator's `period_mode` bit, seen at a rising edge, arms repeating mode. The first deadline is the watched count at that edge plus the live interval. The arming edge itself never fires. Each alarm then moves the deadline forward by the interval.
- R7: The interval write keeps only `wr_data[25:0]`. Higher data bits have no effect on the alarm spacing.
- R8: `int_out` is `int_raw AND int_ena` per bit. A raw bit stays set until an edge at which its `int_clr` bit is 1, and it then reads 0.
- R9: If a comparator fires at the same edge at which its `int_clr` bit is 1, its raw bit ends set.
- R10: A low-word write (`wr_lo`) sets deadline bits 31:0 from `wr_data[31:0]`. An upper-part write (`wr_hi`) sets bits 51:32 from `wr_data[19:0]`. The comparator written is the one indexed by `cmp_sel`. Only one write strobe is raised per clock.
- R11: After synchronous reset, `int_raw`, `evt` and `int_out` are all 0, and no comparator is armed in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_u0 | input | 52 | Count of counter unit 0 |
| cnt_u1 | input | 52 | Count of counter unit 1 |
| cmp_sel | input | 2 | Comparator addressed by the write strobes |
| wr_lo | input | 1 | Write deadline bits 31:0 |
| wr_hi | input | 1 | Write deadline bits 51:32 |
| wr_per | input | 1 | Write interval |
| wr_data | input | 32 | Write data |
| load | input | 3 | Per-comparator commit strobe |
| work_en | input | 3 | Per-comparator alarm enable |
| unit_sel | input | 3 | Per-comparator counter select |
| period_mode | input | 3 | Per-comparator mode (0 one-shot, 1 repeating) |
| int_ena | input | 3 | Interrupt enable mask |
| int_clr | input | 3 | Write-one clear of pending bits |
| int_raw | output | 3 | Sticky pending bits |
| int_out | output | 3 | Masked interrupt lines |
| evt | output | 3 | One-clock alarm event pulses |

## Verification
A compare result sampled at rising edge k shows up on `evt` and `int_raw` right after edge k. A commit pulse or a mode change takes one edge to settle before it can cause an alarm at the next edge. `int_out` follows `int_ena` with no delay. Inputs are changed on the falling edge. A bench model is advanced just after each rising edge, using the inputs that edge saw, and outputs are compared on the next falling edge. Each directed check is therefore placed on the exact edge at which the requirement says the result changes.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_LO   = 2'd1,
    WR_HI   = 2'd2,
    WR_PER  = 2'd3
  } wr_kind_e;

  function automatic wr_kind_e decode_wr(input logic lo, input logic hi, input logic per);
    if (lo)       return WR_LO;
    else if (hi)  return WR_HI;
    else if (per) return WR_PER;
    else          return WR_NONE;
  endfunction
endpackage

// File: rtl/alarm_shadow.sv
module alarm_shadow
  import alarm_pkg::*;
#(
  parameter int CNT_W = 52,
  parameter int PER_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  wr_kind_e          kind,
  input  logic [WORD_W-1:0] data,
  output logic [CNT_W-1:0]  shd_tgt,
  output logic [PER_W-1:0]  shd_per
);
  localparam int HI_W = CNT_W - WORD_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_tgt <= '0;
      shd_per <= '0;
    end else if (sel) begin
      case (kind)
        WR_LO:   shd_tgt[WORD_W-1:0]     <= data;
        WR_HI:   shd_tgt[CNT_W-1:WORD_W] <= data[HI_W-1:0];
        WR_PER:  shd_per                 <= data[PER_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int CNT_W = 52,
  parameter int PER_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  input  logic             unit_sel,
  input  logic             work_en,
  input  logic             period_mode,
  input  logic             load,
  input  logic [CNT_W-1:0] shd_tgt,
  input  logic [PER_W-1:0] shd_per,
  output logic             hit
);
  logic [CNT_W-1:0] act_tgt, nxt_tgt, cnt_sel, per_ext;
  logic [PER_W-1:0] act_per;
  logic             t_armed, p_armed, pm_q;

  assign cnt_sel = unit_sel ? cnt1 : cnt0;
  assign per_ext = {{(CNT_W-PER_W){1'b0}}, act_per};

  always_comb begin
    if (period_mode) hit = work_en & p_armed & (cnt_sel >= nxt_tgt);
    else             hit = work_en & t_armed & (cnt_sel >= act_tgt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_tgt <= '0;
      act_per <= '0;
      nxt_tgt <= '0;
      t_armed <= 1'b0;
      p_armed <= 1'b0;
      pm_q    <= 1'b0;
    end else begin
      pm_q <= period_mode;
      if (load) begin
        act_tgt <= shd_tgt;
        act_per <= shd_per;
        t_armed <= 1'b1;
      end else if (hit && !period_mode) begin
        t_armed <= 1'b0;
      end
      if (!period_mode) begin
        p_armed <= 1'b0;
      end else if (!pm_q) begin
        p_armed <= 1'b1;
        nxt_tgt <= cnt_sel + per_ext;
      end else if (hit) begin
        nxt_tgt <= nxt_tgt + per_ext;
      end
    end
  end

  // R3: a one-shot alarm is not repeated without a new commit
  p_target_once_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && !period_mode && !load) |=> !(hit && !period_mode));

  // R6: the edge that arms repeating mode never fires
  p_arm_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (period_mode && !pm_q) |-> !hit);
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] ena,
  input  logic [N-1:0] clr,
  output logic [N-1:0] raw,
  output logic [N-1:0] evt,
  output logic [N-1:0] irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      evt <= '0;
    end else begin
      raw <= (raw & ~clr) | hit;
      evt <= hit;
    end
  end

  assign irq = raw & ena;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R8: pending bit holds until cleared
    p_raw_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (raw[g] && !clr[g]) |=> raw[g]);
    // R9: a new alarm wins over a clear in the same clock
    p_clr_collision_r9: assert property (@(posedge clk) disable iff (rst)
      (hit[g] && clr[g]) |=> raw[g]);
    // R2: every event pulse leaves its pending bit set
    p_evt_sets_raw_r2: assert property (@(posedge clk) disable iff (rst)
      evt[g] |-> raw[g]);
  end
endmodule

// File: rtl/alarm_bank.sv
module alarm_bank
  import alarm_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 52,
  parameter int PER_W   = 26,
  parameter int SEL_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt_u0,
  input  logic [CNT_W-1:0]   cnt_u1,
  input  logic [SEL_W-1:0]   cmp_sel,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               wr_per,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [NUM_CMP-1:0] load,
  input  logic [NUM_CMP-1:0] work_en,
  input  logic [NUM_CMP-1:0] unit_sel,
  input  logic [NUM_CMP-1:0] period_mode,
  input  logic [NUM_CMP-1:0] int_ena,
  input  logic [NUM_CMP-1:0] int_clr,
  output logic [NUM_CMP-1:0] int_raw,
  output logic [NUM_CMP-1:0] int_out,
  output logic [NUM_CMP-1:0] evt
);
  wr_kind_e           kind;
  logic [NUM_CMP-1:0] hit;

  assign kind = decode_wr(wr_lo, wr_hi, wr_per);

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic [CNT_W-1:0] shd_tgt;
    logic [PER_W-1:0] shd_per;

    alarm_shadow #(.CNT_W(CNT_W), .PER_W(PER_W)) u_shadow (
      .clk     (clk),
      .rst     (rst),
      .sel     (cmp_sel == SEL_W'(g)),
      .kind    (kind),
      .data    (wr_data),
      .shd_tgt (shd_tgt),
      .shd_per (shd_per)
    );

    alarm_cmp #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp (
      .clk         (clk),
      .rst         (rst),
      .cnt0        (cnt_u0),
      .cnt1        (cnt_u1),
      .unit_sel    (unit_sel[g]),
      .work_en     (work_en[g]),
      .period_mode (period_mode[g]),
      .load        (load[g]),
      .shd_tgt     (shd_tgt),
      .shd_per     (shd_per),
      .hit         (hit[g])
    );

    // R5: no event unless the comparator was enabled at the firing edge
    p_enable_gate_r5: assert property (@(posedge clk) disable iff (rst)
      evt[g] |-> $past(work_en[g]));
  end

  alarm_irq #(.N(NUM_CMP)) u_irq (
    .clk (clk),
    .rst (rst),
    .hit (hit),
    .ena (int_ena),
    .clr (int_clr),
    .raw (int_raw),
    .evt (evt),
    .irq (int_out)
  );
endmodule

// File: tb/alarm_bank_tb.sv
module alarm_bank_tb;
  localparam int N  = 3;
  localparam int CW = 52;
  localparam int PW = 26;
  localparam int WW = 32;
  localparam int SW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [CW-1:0] cnt0, cnt1;
  logic [SW-1:0] cmp_sel;
  logic          wr_lo, wr_hi, wr_per;
  logic [WW-1:0] wr_data;
  logic [N-1:0]  load, work_en, unit_sel, period_mode, int_ena, int_clr;
  logic [N-1:0]  int_raw, int_out, evt;

  alarm_bank u_dut (
    .clk(clk), .rst(rst), .cnt_u0(cnt0), .cnt_u1(cnt1), .cmp_sel(cmp_sel),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_per(wr_per), .wr_data(wr_data),
    .load(load), .work_en(work_en), .unit_sel(unit_sel),
    .period_mode(period_mode), .int_ena(int_ena), .int_clr(int_clr),
    .int_raw(int_raw), .int_out(int_out), .evt(evt)
  );

  // bench reference state, built from the requirements
  logic [CW-1:0] m_sh [N];
  logic [CW-1:0] m_tgt[N];
  logic [CW-1:0] m_nxt[N];
  logic [PW-1:0] m_shp[N];
  logic [PW-1:0] m_per[N];
  logic [N-1:0]  m_ta, m_pa, m_pmq, m_raw, m_evt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_sh[i] = '0; m_tgt[i] = '0; m_nxt[i] = '0; m_shp[i] = '0; m_per[i] = '0;
    end
    m_ta = '0; m_pa = '0; m_pmq = '0; m_raw = '0; m_evt = '0;
  endtask

  task automatic model_step();
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) begin
      logic [CW-1:0] c;
      logic [PW-1:0] old_per;
      c = unit_sel[i] ? cnt1 : cnt0;
      old_per = m_per[i];
      if (period_mode[i]) h[i] = work_en[i] && m_pa[i] && (c >= m_nxt[i]);
      else                h[i] = work_en[i] && m_ta[i] && (c >= m_tgt[i]);
      if (load[i]) begin
        m_tgt[i] = m_sh[i]; m_per[i] = m_shp[i]; m_ta[i] = 1'b1;
      end else if (h[i] && !period_mode[i]) m_ta[i] = 1'b0;
      if (!period_mode[i]) m_pa[i] = 1'b0;
      else if (!m_pmq[i]) begin
        m_pa[i] = 1'b1; m_nxt[i] = c + CW'(old_per);
      end else if (h[i]) m_nxt[i] = m_nxt[i] + CW'(old_per);
      m_pmq[i] = period_mode[i];
      if (cmp_sel == SW'(i)) begin
        if (wr_lo)       m_sh[i][31:0]  = wr_data;
        else if (wr_hi)  m_sh[i][51:32] = wr_data[19:0];
        else if (wr_per) m_shp[i]       = wr_data[PW-1:0];
      end
    end
    m_raw = (m_raw & ~int_clr) | h;
    m_evt = h;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    if (!rst) begin
      chk("R2/R6 evt vs model", 64'(evt), 64'(m_evt));
      chk("R8/R9 raw vs model", 64'(int_raw), 64'(m_raw));
      chk("R8 int_out vs model", 64'(int_out), 64'(m_raw & int_ena));
    end
  endtask

  task automatic wr(input int s, input int kind, input logic [WW-1:0] d);
    cmp_sel = SW'(s);
    wr_lo = (kind == 0); wr_hi = (kind == 1); wr_per = (kind == 2);
    wr_data = d;
    tick();
    wr_lo = 0; wr_hi = 0; wr_per = 0;
  endtask

  task automatic pulse_load(input int s);
    load[s] = 1'b1;
    tick();
    load = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1; cnt0 = 52'd10; cnt1 = '0; cmp_sel = '0;
    wr_lo = 0; wr_hi = 0; wr_per = 0; wr_data = '0;
    load = '0; work_en = '1; unit_sel = '0; period_mode = '0;
    int_ena = '0; int_clr = '0;
    model_reset();
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    tick();
    chk("R11 raw after reset", 64'(int_raw), 64'd0);
    chk("R11 evt after reset", 64'(evt), 64'd0);
    chk("R11 int_out after reset", 64'(int_out), 64'd0);

    // R1: staged writes stay hidden until commit
    wr(0, 0, 1000); wr(0, 1, 0); pulse_load(0);
    cnt0 = 52'd20; tick();
    wr(0, 0, 5); tick();
    chk("R1 staged deadline ignored", 64'(evt[0]), 64'd0);
    // R2: commit, then fire on the next edge
    pulse_load(0); tick();
    chk("R2 one-shot event", 64'(evt[0]), 64'd1);
    chk("R2 raw set", 64'(int_raw[0]), 64'd1);
    // R3: no repeat
    tick();
    chk("R3 no second event", 64'(evt[0]), 64'd0);
    cnt0 = 52'd40; tick();
    chk("R3 still quiet", 64'(evt[0]), 64'd0);
    // R8: masking and clear
    int_ena[0] = 0; tick();
    chk("R8 masked line", 64'(int_out[0]), 64'd0);
    int_ena[0] = 1; tick();
    chk("R8 enabled line", 64'(int_out[0]), 64'd1);
    int_clr[0] = 1; tick(); int_clr[0] = 0;
    chk("R8 raw cleared", 64'(int_raw[0]), 64'd0);
    // R9: clear collides with a new alarm
    pulse_load(0); tick();
    pulse_load(0);
    int_clr[0] = 1; tick(); int_clr[0] = 0;
    chk("R9 raw kept on collision", 64'(int_raw[0]), 64'd1);
    chk("R9 event on collision", 64'(evt[0]), 64'd1);
    // R10: word halves, upper data bits of hi write dropped
    wr(1, 1, 32'hFFF0_0001); wr(1, 0, 0); pulse_load(1);
    cnt0 = 52'h0_FFFF_FFFF; tick();
    chk("R10 below split deadline", 64'(evt[1]), 64'd0);
    cnt0 = 52'h1_0000_0000; tick();
    chk("R10 at split deadline", 64'(evt[1]), 64'd1);
    // R4 / R5: counter select and enable
    unit_sel[2] = 1; cnt1 = 52'd100; cnt0 = 52'h8_0000_0000;
    wr(2, 0, 300); wr(2, 1, 0); pulse_load(2); tick();
    chk("R4 unit 1 below deadline", 64'(evt[2]), 64'd0);
    cnt1 = 52'd300; work_en[2] = 0; tick();
    chk("R5 disabled holds alarm", 64'(evt[2]), 64'd0);
    work_en[2] = 1; tick();
    chk("R4/R5 fires on unit 1 after enable", 64'(evt[2]), 64'd1);
    // R6: repeating mode
    cnt0 = 52'd1000;
    wr(1, 2, 10); pulse_load(1);
    period_mode[1] = 1; tick();
    chk("R6 arming edge quiet", 64'(evt[1]), 64'd0);
    cnt0 = 52'd1009; tick(); chk("R6 before first", 64'(evt[1]), 64'd0);
    cnt0 = 52'd1010; tick(); chk("R6 first alarm", 64'(evt[1]), 64'd1);
    cnt0 = 52'd1019; tick(); chk("R6 between", 64'(evt[1]), 64'd0);
    cnt0 = 52'd1020; tick(); chk("R6 second alarm", 64'(evt[1]), 64'd1);
    // R7: interval truncated to 26 bits
    wr(1, 2, 32'hFC00_0004); pulse_load(1);
    period_mode[1] = 0; tick();
    period_mode[1] = 1; cnt0 = 52'd2000; tick();
    cnt0 = 52'd2003; tick(); chk("R7 before truncated interval", 64'(evt[1]), 64'd0);
    cnt0 = 52'd2004; tick(); chk("R7 at truncated interval", 64'(evt[1]), 64'd1);

    // constrained random phase against the model
    for (int k = 0; k < 4000; k++) begin
      int r;
      int s;
      cnt0 = cnt0 + CW'($urandom_range(0, 3));
      cnt1 = cnt1 + CW'($urandom_range(0, 2));
      r = $urandom_range(0, 15);
      s = $urandom_range(0, N - 1);
      cmp_sel = SW'(s);
      wr_lo = (r == 0); wr_hi = (r == 1); wr_per = (r == 2);
      if (r == 0) wr_data = cnt0[31:0] + 32'($urandom_range(0, 60));
      else if (r == 1) wr_data = {12'h0, cnt0[51:32]};
      else wr_data = 32'($urandom_range(0, 30)) | (($urandom_range(0, 3) == 0) ? 32'hFC00_0000 : 32'h0);
      for (int i = 0; i < N; i++) begin
        load[i] = ($urandom_range(0, 11) == 0);
        if ($urandom_range(0, 39) == 0) period_mode[i] = ~period_mode[i];
        if ($urandom_range(0, 29) == 0) work_en[i] = ~work_en[i];
        if ($urandom_range(0, 59) == 0) unit_sel[i] = ~unit_sel[i];
        int_clr[i] = ($urandom_range(0, 7) == 0);
      end
      int_ena = N'($urandom);
      tick();
    end
    wr_lo = 0; wr_hi = 0; wr_per = 0; load = '0; int_clr = '0;
    tick();
    finish_run();
  end
endmodule